// File: doc/BRIEF.md
# UART Xon/Xoff Flow Control Engine

This block adds in-band software flow control to one UART channel. It sits on the receive path between the character receiver and the receive FIFO write port. Each received character is tested against programmable pause and resume patterns. Recognised control characters are removed from the stream, and a pause line toward the transmitter is set or cleared. A pattern can be one character or an ordered pair of characters.

On the transmit side, two FIFO level inputs ask the block to send a pause or resume pattern to the far end. The request is offered on a dedicated insertion port that the transmitter serves ahead of normal data.

A special-detect mode replaces flow control. In this mode every character is stored, and a sticky flag reports any arrival of one chosen character. A separate gate protects a small field of extended settings against writes.

Characters on `rx_valid` must be at least two cycles apart. A released pending byte and the byte that follows it reach the FIFO port in two consecutive cycles.

Top module: `sfc_engine`

## Requirements
- R1: After reset, every configuration register and `ext_fields` read as zero, and `fifo_we`, `tx_pause`, `spec_flag` and `ins_valid` are low.
- R2: Register addresses are: 0 resume char A, 1 resume char B, 2 pause char A, 3 pause char B, 4 control, 5 extended field. Control bit 5 is special-detect enable, bit 4 is the extended-write gate, bits 3:2 select the transmit mode and bits 1:0 select the receive mode. In each mode field, 00 means off, 10 uses the A characters, 01 uses the B characters and 11 uses the pair A then B.
- R3: In a single-character receive mode, a character equal to the selected pause char (compared over all bits) is dropped and sets `tx_pause`. A character equal to the selected resume char is dropped and clears `tx_pause`. Any other character is written to the FIFO port one cycle after `rx_valid`.
- R4: In pair receive mode, a character equal to char A is held back. If the next character is the matching char B, both are dropped and the pause state is updated. If it is not, the held byte is written first and the new byte is then handled as a fresh character, either stored in the next cycle or held back.
- R5: While `xon_any` is high and a receive mode is active, any received character that is not a completed pause pattern clears `tx_pause`.
- R6: With the receive mode off, every character is stored unchanged and `tx_pause` is low from the next cycle.
- R7: With special detect on, both mode fields are treated as off. Every character is stored, and a character equal to pause char B sets `spec_flag`. A pulse on `stat_rd` clears the flag, but a set in the same cycle wins.
- R8: With a transmit mode active, a high `fifo_above_hi` in the resume state inserts the selected pause character or characters exactly once. A high `fifo_below_lo` in the pause state then inserts the resume characters exactly once.
- R9: `ins_valid` and `ins_data` stay fixed until `tx_take` accepts the character. In pair mode the B character follows the accepted A character.
- R10: Writes to address 5 change `ext_fields` only while control bit 4 is set. Otherwise the field keeps its latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CW | Register write data |
| ext_fields | output | EW | Write-gated extended settings |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CW | Received character |
| xon_any | input | 1 | Any character resumes transmission |
| stat_rd | input | 1 | Status read strobe, clears `spec_flag` |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_data | output | CW | Receive FIFO write data |
| tx_pause | output | 1 | Hold the transmitter |
| spec_flag | output | 1 | Special character seen |
| fifo_above_hi | input | 1 | Receive FIFO above high mark |
| fifo_below_lo | input | 1 | Receive FIFO below low mark |
| tx_take | input | 1 | Transmitter accepts inserted character |
| ins_valid | output | 1 | Inserted character pending |
| ins_data | output | CW | Inserted character |

## Verification
Setting the special flag and clearing it by a status read can fall in the same cycle. The bench drives a matching character together with a `stat_rd` pulse and expects the flag to stay set. A second collision happens in pair mode, where releasing a held byte meets the arrival of an unrelated byte. The bench sweeps all sixteen mode fields, with special detect on and off and with `xon_any` on and off, over one stream that contains broken and interleaved pairs. It checks the exact order of FIFO writes and the pause level against a model of the requirements.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    FM_NONE = 2'b00,
    FM_SETB = 2'b01,
    FM_SETA = 2'b10,
    FM_PAIR = 2'b11
  } fc_mode_e;

  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_ON   = 2'b01,
    PK_OFF  = 2'b10
  } pend_e;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NCHR   = 4;
  localparam int unsigned CTRL_W = 6;
  localparam logic [ADDR_W-1:0] A_ONA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ONB  = 3'd1;
  localparam logic [ADDR_W-1:0] A_OFFA = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFFB = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_EXT  = 3'd5;
  localparam int unsigned B_GATE = 4;
  localparam int unsigned B_SPEC = 5;
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned EW = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     on_a,
  output logic [CW-1:0]     on_b,
  output logic [CW-1:0]     off_a,
  output logic [CW-1:0]     off_b,
  output fc_mode_e          tx_mode,
  output fc_mode_e          rx_mode,
  output logic              spec_en,
  output logic [EW-1:0]     ext_q
);
  logic [NCHR-1:0][CW-1:0] chr_q;
  logic [NCHR-1:0][CW-1:0] chr_d;
  logic [CTRL_W-1:0]       ctrl_q, ctrl_d;
  logic [EW-1:0]           ext_d;

  for (genvar g = 0; g < NCHR; g++) begin : g_chr
    always_comb begin
      chr_d[g] = chr_q[g];
      if (wr_en && (wr_addr == ADDR_W'(g))) chr_d[g] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) chr_q[g] <= '0;
      else         chr_q[g] <= chr_d[g];
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    ext_d  = ext_q;
    if (wr_en && wr_addr == A_CTRL) ctrl_d = wr_data[CTRL_W-1:0];
    if (wr_en && wr_addr == A_EXT && ctrl_q[B_GATE]) ext_d = wr_data[EW-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ext_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ext_q  <= ext_d;
    end
  end

  assign on_a    = chr_q[A_ONA];
  assign on_b    = chr_q[A_ONB];
  assign off_a   = chr_q[A_OFFA];
  assign off_b   = chr_q[A_OFFB];
  assign spec_en = ctrl_q[B_SPEC];
  assign tx_mode = spec_en ? FM_NONE : fc_mode_e'(ctrl_q[3:2]);
  assign rx_mode = spec_en ? FM_NONE : fc_mode_e'(ctrl_q[1:0]);

  // R10
  ext_lock_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_addr == A_EXT && !ctrl_q[B_GATE]) |=> $stable(ext_q));
endmodule

// File: rtl/sfc_rx_filter.sv
module sfc_rx_filter
  import sfc_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  input  fc_mode_e      rx_mode,
  input  logic          spec_en,
  input  logic [CW-1:0] on_a,
  input  logic [CW-1:0] on_b,
  input  logic [CW-1:0] off_a,
  input  logic [CW-1:0] off_b,
  input  logic          xon_any,
  input  logic          stat_rd,
  output logic          fifo_we,
  output logic [CW-1:0] fifo_data,
  output logic          tx_pause,
  output logic          spec_flag
);
  pend_e         pend_q, pend_d;
  logic [CW-1:0] pdat_q, pdat_d;
  logic          spill_q, spill_d;
  logic [CW-1:0] sdat_q, sdat_d;
  logic          we_d;
  logic [CW-1:0] dat_d;
  logic          pause_d, flag_d;
  logic          on_ev, off_ev, fresh, rel;
  logic [CW-1:0] on_c, off_c;

  assign on_c  = (rx_mode == FM_SETB) ? on_b  : on_a;
  assign off_c = (rx_mode == FM_SETB) ? off_b : off_a;

  always_comb begin
    pend_d  = pend_q;
    pdat_d  = pdat_q;
    spill_d = 1'b0;
    sdat_d  = sdat_q;
    we_d    = 1'b0;
    dat_d   = fifo_data;
    pause_d = tx_pause;
    flag_d  = spec_flag & ~stat_rd;
    on_ev   = 1'b0;
    off_ev  = 1'b0;
    fresh   = 1'b1;
    rel     = 1'b0;
    if (spill_q) begin
      we_d  = 1'b1;
      dat_d = sdat_q;
    end
    if (rx_mode != FM_PAIR) pend_d = PK_NONE;
    if (rx_valid) begin
      if (spec_en) begin
        we_d  = 1'b1;
        dat_d = rx_data;
        if (rx_data == off_b) flag_d = 1'b1;
      end else begin
        case (rx_mode)
          FM_SETA, FM_SETB: begin
            if (rx_data == off_c)     off_ev = 1'b1;
            else if (rx_data == on_c) on_ev  = 1'b1;
            else begin
              we_d  = 1'b1;
              dat_d = rx_data;
            end
          end
          FM_PAIR: begin
            if (pend_q == PK_ON && rx_data == on_b) begin
              on_ev  = 1'b1;
              fresh  = 1'b0;
              pend_d = PK_NONE;
            end else if (pend_q == PK_OFF && rx_data == off_b) begin
              off_ev = 1'b1;
              fresh  = 1'b0;
              pend_d = PK_NONE;
            end else if (pend_q != PK_NONE) begin
              rel    = 1'b1;
              we_d   = 1'b1;
              dat_d  = pdat_q;
              pend_d = PK_NONE;
            end
            if (fresh) begin
              if (rx_data == off_a) begin
                pend_d = PK_OFF;
                pdat_d = rx_data;
              end else if (rx_data == on_a) begin
                pend_d = PK_ON;
                pdat_d = rx_data;
              end else if (rel) begin
                spill_d = 1'b1;
                sdat_d  = rx_data;
              end else begin
                we_d  = 1'b1;
                dat_d = rx_data;
              end
            end
          end
          default: begin
            we_d  = 1'b1;
            dat_d = rx_data;
          end
        endcase
        if (off_ev)                pause_d = 1'b1;
        else if (on_ev || xon_any) pause_d = 1'b0;
      end
    end
    if (rx_mode == FM_NONE) pause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= PK_NONE;
      pdat_q    <= '0;
      spill_q   <= 1'b0;
      sdat_q    <= '0;
      fifo_we   <= 1'b0;
      fifo_data <= '0;
      tx_pause  <= 1'b0;
      spec_flag <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      pdat_q    <= pdat_d;
      spill_q   <= spill_d;
      sdat_q    <= sdat_d;
      fifo_we   <= we_d;
      fifo_data <= dat_d;
      tx_pause  <= pause_d;
      spec_flag <= flag_d;
    end
  end

  // R3
  single_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_valid && rx_mode == FM_SETA && rx_data == off_a) |=> tx_pause);
  // R6
  idle_pause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_mode == FM_NONE) |=> !tx_pause);
  // R7
  spec_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_valid && spec_en && rx_data == off_b) |=> (spec_flag && fifo_we));
endmodule

// File: rtl/sfc_tx_insert.sv
module sfc_tx_insert
  import sfc_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  fc_mode_e      tx_mode,
  input  logic [CW-1:0] on_a,
  input  logic [CW-1:0] on_b,
  input  logic [CW-1:0] off_a,
  input  logic [CW-1:0] off_b,
  input  logic          above_hi,
  input  logic          below_lo,
  input  logic          tx_take,
  output logic          ins_valid,
  output logic [CW-1:0] ins_data
);
  logic          busy_d, kind_q, kind_d, more_q, more_d, off_st_q, off_st_d;
  logic [CW-1:0] dat_d;
  logic          start, skind;

  always_comb begin
    busy_d   = ins_valid;
    kind_d   = kind_q;
    more_d   = more_q;
    off_st_d = off_st_q;
    dat_d    = ins_data;
    start    = 1'b0;
    skind    = 1'b0;
    if (!ins_valid) begin
      if (tx_mode == FM_NONE) off_st_d = 1'b0;
      else if (!off_st_q && above_hi) begin
        start = 1'b1;
        skind = 1'b1;
      end else if (off_st_q && below_lo) begin
        start = 1'b1;
      end
      if (start) begin
        busy_d = 1'b1;
        kind_d = skind;
        more_d = (tx_mode == FM_PAIR);
        if (skind) dat_d = (tx_mode == FM_SETB) ? off_b : off_a;
        else       dat_d = (tx_mode == FM_SETB) ? on_b  : on_a;
      end
    end else if (tx_take) begin
      if (more_q) begin
        more_d = 1'b0;
        dat_d  = kind_q ? off_b : on_b;
      end else begin
        busy_d   = 1'b0;
        off_st_d = kind_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_valid <= 1'b0;
      kind_q    <= 1'b0;
      more_q    <= 1'b0;
      off_st_q  <= 1'b0;
      ins_data  <= '0;
    end else begin
      ins_valid <= busy_d;
      kind_q    <= kind_d;
      more_q    <= more_d;
      off_st_q  <= off_st_d;
      ins_data  <= dat_d;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ins_valid && !tx_take) |=> (ins_valid && $stable(ins_data)));
  // R8
  gap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ins_valid && tx_take && !more_q) |=> !ins_valid);
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
  import sfc_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned EW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [EW-1:0]     ext_fields,
  input  logic              rx_valid,
  input  logic [CW-1:0]     rx_data,
  input  logic              xon_any,
  input  logic              stat_rd,
  output logic              fifo_we,
  output logic [CW-1:0]     fifo_data,
  output logic              tx_pause,
  output logic              spec_flag,
  input  logic              fifo_above_hi,
  input  logic              fifo_below_lo,
  input  logic              tx_take,
  output logic              ins_valid,
  output logic [CW-1:0]     ins_data
);
  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic [CW-1:0] on_a, on_b, off_a, off_b;
  fc_mode_e      tx_mode, rx_mode;
  logic          spec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sfc_regs #(.CW(CW), .EW(EW)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .on_a(on_a), .on_b(on_b), .off_a(off_a),
    .off_b(off_b), .tx_mode(tx_mode), .rx_mode(rx_mode),
    .spec_en(spec_en), .ext_q(ext_fields)
  );

  sfc_rx_filter #(.CW(CW)) u_rx (
    .clk(clk), .rst_ni(rst_ni), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_mode(rx_mode), .spec_en(spec_en), .on_a(on_a), .on_b(on_b),
    .off_a(off_a), .off_b(off_b), .xon_any(xon_any), .stat_rd(stat_rd),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .tx_pause(tx_pause),
    .spec_flag(spec_flag)
  );

  sfc_tx_insert #(.CW(CW)) u_tx (
    .clk(clk), .rst_ni(rst_ni), .tx_mode(tx_mode), .on_a(on_a),
    .on_b(on_b), .off_a(off_a), .off_b(off_b), .above_hi(fifo_above_hi),
    .below_lo(fifo_below_lo), .tx_take(tx_take), .ins_valid(ins_valid),
    .ins_data(ins_data)
  );
endmodule

// File: tb/test_sfc_engine.sv
`timescale 1ns/1ps
module test_sfc_engine;
  localparam int CW = 8;
  localparam int EW = 7;
  localparam logic [7:0] ONA = 8'h11, ONB = 8'h12, OFFA = 8'h13, OFFB = 8'h93;
  localparam int NS = 15;
  localparam logic [7:0] STREAM [NS] = '{8'h13, 8'h41, 8'h11, 8'h13, 8'h93,
    8'h42, 8'h11, 8'h12, 8'h93, 8'h13, 8'h12, 8'h11, 8'h11, 8'h12, 8'h44};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, rx_valid, xon_any, stat_rd, above_hi, below_lo, tx_take;
  logic [2:0] wr_addr;
  logic [CW-1:0] wr_data, rx_data, fifo_data, ins_data;
  logic [EW-1:0] ext_fields;
  logic fifo_we, tx_pause, spec_flag, ins_valid;

  sfc_engine #(.CW(CW), .EW(EW)) i_sfc_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_fields(ext_fields), .rx_valid(rx_valid),
    .rx_data(rx_data), .xon_any(xon_any), .stat_rd(stat_rd),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .tx_pause(tx_pause),
    .spec_flag(spec_flag), .fifo_above_hi(above_hi),
    .fifo_below_lo(below_lo), .tx_take(tx_take), .ins_valid(ins_valid),
    .ins_data(ins_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] got [64];
  logic [7:0] exp_q [64];
  logic [7:0] ins_got [16];
  int ng = 0, ne = 0, ni = 0;

  int  rxm, pk;
  bit  m_spec, m_xa, p, eflag;
  logic [7:0] pd;

  always begin
    @(negedge clk); #1;
    if (fifo_we && ng < 64) begin got[ng] = fifo_data; ng++; end
    if (ins_valid && tx_take && ni < 16) begin ins_got[ni] = ins_data; ni++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] c);
    exp_q[ne] = c; ne++;
  endtask

  task automatic model_char(input logic [7:0] c);
    bit on_e, off_e, fr, rl;
    logic [7:0] onc, offc;
    on_e = 0; off_e = 0; fr = 1; rl = 0;
    onc = (rxm == 1) ? ONB : ONA;
    offc = (rxm == 1) ? OFFB : OFFA;
    if (m_spec) begin
      push(c);
      if (c == OFFB) eflag = 1;
    end else if (rxm == 0) push(c);
    else if (rxm != 3) begin
      if (c == offc) off_e = 1;
      else if (c == onc) on_e = 1;
      else push(c);
    end else begin
      if (pk == 1 && c == ONB) begin on_e = 1; fr = 0; pk = 0; end
      else if (pk == 2 && c == OFFB) begin off_e = 1; fr = 0; pk = 0; end
      else if (pk != 0) begin push(pd); pk = 0; end
      if (fr) begin
        if (c == OFFA) begin pk = 2; pd = c; end
        else if (c == ONA) begin pk = 1; pd = c; end
        else push(c);
      end
    end
    if (!m_spec && rxm != 0) begin
      if (off_e) p = 1;
      else if (on_e || m_xa) p = 0;
    end else p = 0;
  endtask

  task automatic run_rx(input int f, input bit s, input bit xa);
    string tag;
    wr(3'd4, {2'b00, s, 1'b0, f[3:0]});
    @(negedge clk); xon_any = xa;
    ng = 0; ne = 0; p = 0; pk = 0; eflag = 0;
    m_spec = s; m_xa = xa; rxm = s ? 0 : (f & 3);
    if (s) tag = "R7";
    else if (rxm == 0) tag = "R6";
    else if (xa) tag = "R5";
    else if (rxm == 3) tag = "R4";
    else tag = "R3";
    for (int i = 0; i < NS; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = STREAM[i];
      @(negedge clk); rx_valid = 1'b0;
      @(negedge clk); @(negedge clk);
      model_char(STREAM[i]);
      chk(tx_pause == p, {tag, " pause"}, int'(tx_pause), int'(p));
    end
    chk(ng == ne, {tag, " fifo count"}, ng, ne);
    for (int i = 0; i < ne && i < ng; i++)
      chk(got[i] == exp_q[i], {tag, " fifo data"}, int'(got[i]), int'(exp_q[i]));
    if (s) begin
      chk(spec_flag == eflag, "R7 flag set", int'(spec_flag), int'(eflag));
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
      chk(spec_flag == 1'b0, "R7 flag clear", int'(spec_flag), 0);
    end
    wr(3'd4, 8'h00);
    xon_any = 1'b0;
    @(negedge clk);
    chk(tx_pause == 1'b0, "R6 pause off", int'(tx_pause), 0);
  endtask

  task automatic expect_ins(input int m, input bit off, input string tag);
    logic [7:0] e0, e1;
    int n;
    e0 = off ? ((m == 1) ? OFFB : OFFA) : ((m == 1) ? ONB : ONA);
    e1 = off ? OFFB : ONB;
    n = (m == 0) ? 0 : (m == 3) ? 2 : 1;
    chk(ni == n, {tag, " insert count"}, ni, n);
    if (n > 0 && ni > 0) chk(ins_got[0] == e0, {tag, " insert first"}, int'(ins_got[0]), int'(e0));
    if (n > 1 && ni > 1) chk(ins_got[1] == e1, {tag, " insert second"}, int'(ins_got[1]), int'(e1));
  endtask

  task automatic run_tx(input int tf, input bit s);
    int m;
    m = s ? 0 : tf;
    wr(3'd4, {2'b00, s, 1'b0, tf[1:0], 2'b00});
    @(negedge clk); tx_take = 1'b1; ni = 0; above_hi = 1'b1;
    repeat (10) @(negedge clk);
    above_hi = 1'b0;
    repeat (3) @(negedge clk);
    expect_ins(m, 1'b1, s ? "R7 R8 pause" : "R8 pause");
    ni = 0; below_lo = 1'b1;
    repeat (10) @(negedge clk);
    below_lo = 1'b0;
    repeat (3) @(negedge clk);
    expect_ins(m, 1'b0, s ? "R7 R8 resume" : "R8 resume");
    ni = 0; below_lo = 1'b1;
    repeat (6) @(negedge clk);
    below_lo = 1'b0;
    chk(ni == 0, "R8 no repeat", ni, 0);
    wr(3'd4, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rx_valid = 1'b0;
    rx_data = '0; xon_any = 1'b0; stat_rd = 1'b0; above_hi = 1'b0;
    below_lo = 1'b0; tx_take = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(fifo_we == 0, "R1 fifo_we", int'(fifo_we), 0);
    chk(tx_pause == 0, "R1 tx_pause", int'(tx_pause), 0);
    chk(ins_valid == 0, "R1 ins_valid", int'(ins_valid), 0);
    chk(spec_flag == 0, "R1 spec_flag", int'(spec_flag), 0);
    chk(ext_fields == 0, "R1 ext_fields", int'(ext_fields), 0);
    // R10 gated extended field
    wr(3'd5, 8'h5A);
    @(negedge clk);
    chk(ext_fields == 0, "R10 write blocked", int'(ext_fields), 0);
    wr(3'd4, 8'h10);
    wr(3'd5, 8'h2A);
    @(negedge clk);
    chk(ext_fields == 7'h2A, "R10 write open", int'(ext_fields), 'h2A);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h55);
    @(negedge clk);
    chk(ext_fields == 7'h2A, "R10 value latched", int'(ext_fields), 'h2A);
    // R2 character registers
    wr(3'd0, ONA); wr(3'd1, ONB); wr(3'd2, OFFA); wr(3'd3, OFFB);
    // R3 R4 R5 R6 R7 sweep of receive configurations
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 16; f++)
        for (int xa = 0; xa < 2; xa++)
          run_rx(f, s[0], xa[0]);
    // R7 set and clear in one cycle: set wins
    wr(3'd4, 8'h20);
    @(negedge clk); rx_valid = 1'b1; rx_data = OFFB; stat_rd = 1'b1;
    @(negedge clk); rx_valid = 1'b0; stat_rd = 1'b0;
    chk(spec_flag == 1'b1, "R7 set beats clear", int'(spec_flag), 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk(spec_flag == 1'b0, "R7 clear", int'(spec_flag), 0);
    wr(3'd4, 8'h00);
    // R8 transmit insertion per mode
    for (int tf = 0; tf < 4; tf++) run_tx(tf, 1'b0);
    run_tx(3, 1'b1);
    // R9 hold until taken, then second of pair
    wr(3'd4, 8'h0C);
    @(negedge clk); tx_take = 1'b0; above_hi = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(ins_valid == 1'b1, "R9 held valid", int'(ins_valid), 1);
      chk(ins_data == OFFA, "R9 held data", int'(ins_data), int'(OFFA));
      @(negedge clk);
    end
    tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
    chk(ins_valid == 1'b1, "R9 second valid", int'(ins_valid), 1);
    chk(ins_data == OFFB, "R9 second data", int'(ins_data), int'(OFFB));
    tx_take = 1'b1; above_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk(ins_valid == 1'b0, "R9 done", int'(ins_valid), 0);
    wr(3'd4, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule